// File: doc/BRIEF.md
# Edge Match-Action Tag Insertion Table

This block is one match+action stage in the ingress pipeline of an edge switch. Each cycle it may receive a parsed header record: the 48-bit destination address, the 12-bit VLAN identifier, a 32-bit source-route tag with its presence flag, and the egress port carried as metadata. It looks the address and VLAN pair up in a small table of fixed size. The winning entry's action is then applied to the record, and the result is registered one cycle later. The action either leaves the record alone, marks it for dropping, or inserts a routing tag and steers the packet to an egress port. The tag is four one-byte hop fields, packed most significant byte first.

A miss does not leave the record untouched by default. It applies the action held in a default register, and the control plane can rewrite that register. Through the same control port the control plane writes and deletes individual entries while lookups go on every cycle. A lookup always sees the table as it stood before any control update in that same cycle.

Top module: `tag_insert_table`

## Requirements
- R1: An entry hits only when it is valid and both its stored destination address and its VLAN identifier equal those of the incoming record. A difference in either field gives a miss.
- R2: `out_valid` equals `in_valid` of the previous cycle. The record outputs change only in a cycle following one where `in_valid` was 1, and they hold their values otherwise.
- R3: Action code 1 (insert tag) sets `out_tag_present` to 1 and `out_tag` to the entry's 32-bit tag, and sets `out_egress` to the entry's port. `out_dmac`, `out_vid` and `out_drop`=0 come from the incoming record unchanged.
- R4: Action code 2 (drop) sets `out_drop` to 1 and passes every header and metadata field unchanged.
- R5: Action codes 0 and 3 (no-op) pass the whole record unchanged, with `out_drop` at 0.
- R6: On a miss, the action, tag and port come from the default register, and `out_hit` is 0. A cycle with `cfg_dflt_wr`=1 loads the register from `cfg_act`, `cfg_tag` and `cfg_port`. After reset the register holds action 0, tag 0 and port 0.
- R7: When several valid entries match, the entry with the lowest index supplies the action.
- R8: `cfg_wr`=1 loads entry `cfg_idx` with the key, action, tag and port and marks it valid. `cfg_del`=1 marks it invalid. When both are 1 in the same cycle, the delete wins.
- R9: A lookup in the same cycle as a control write or delete uses the table contents from before that update. The update takes effect from the next lookup.
- R10: After reset every entry is invalid and all outputs are 0.
- R11: The action reads only the incoming record. Tag insertion replaces an incoming tag and an incoming egress port regardless of their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Incoming record valid |
| in_dmac | input | 48 | Destination address |
| in_vid | input | 12 | VLAN identifier |
| in_tag_present | input | 1 | Record already carries a routing tag |
| in_tag | input | 32 | Incoming routing tag |
| in_egress | input | PORT_W | Incoming egress port metadata |
| cfg_wr | input | 1 | Write entry `cfg_idx` |
| cfg_del | input | 1 | Delete entry `cfg_idx` |
| cfg_dflt_wr | input | 1 | Load the miss (default) action register |
| cfg_idx | input | IDX_W | Entry index |
| cfg_dmac | input | 48 | Key address to store |
| cfg_vid | input | 12 | Key VLAN to store |
| cfg_act | input | 2 | Action code: 0 no-op, 1 insert tag, 2 drop, 3 no-op |
| cfg_tag | input | 32 | Tag value to store |
| cfg_port | input | PORT_W | Egress port to store |
| out_valid | output | 1 | Output record valid |
| out_hit | output | 1 | Lookup matched an entry |
| out_drop | output | 1 | Packet marked for dropping |
| out_dmac | output | 48 | Destination address out |
| out_vid | output | 12 | VLAN identifier out |
| out_tag_present | output | 1 | Routing tag present |
| out_tag | output | 32 | Routing tag out |
| out_egress | output | PORT_W | Egress port out |

## Verification
The hardest case to reach from the ports is a lookup of the very entry that a control write or delete changes in the same clock cycle. Here the result must come from the old contents. The bench makes this case directly: it drives `cfg_wr` or `cfg_del` for an index in the same cycle as `in_valid` with that entry's key, then repeats the lookup on the following cycle to see the change. Overlapping keys in two entries, followed by deleting the lower one, show the priority order. A pseudo-random phase then draws keys from a small shared pool so that hits, misses and updates mix, and a behavioural model checks every field on every clock.

// File: rtl/tag_insert_table.sv
module tag_insert_table #(
  parameter int ENTRIES = 8,
  parameter int PORT_W  = 4,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [47:0]       in_dmac,
  input  logic [11:0]       in_vid,
  input  logic              in_tag_present,
  input  logic [31:0]       in_tag,
  input  logic [PORT_W-1:0] in_egress,
  input  logic              cfg_wr,
  input  logic              cfg_del,
  input  logic              cfg_dflt_wr,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [47:0]       cfg_dmac,
  input  logic [11:0]       cfg_vid,
  input  logic [1:0]        cfg_act,
  input  logic [31:0]       cfg_tag,
  input  logic [PORT_W-1:0] cfg_port,
  output logic              out_valid,
  output logic              out_hit,
  output logic              out_drop,
  output logic [47:0]       out_dmac,
  output logic [11:0]       out_vid,
  output logic              out_tag_present,
  output logic [31:0]       out_tag,
  output logic [PORT_W-1:0] out_egress
);
  localparam logic [1:0] ACT_INSERT = 2'd1;
  localparam logic [1:0] ACT_DROP   = 2'd2;

  logic [ENTRIES-1:0] vld;
  logic [47:0]        k_dmac [ENTRIES];
  logic [11:0]        k_vid  [ENTRIES];
  logic [1:0]         e_act  [ENTRIES];
  logic [31:0]        e_tag  [ENTRIES];
  logic [PORT_W-1:0]  e_port [ENTRIES];

  logic [1:0]         d_act;
  logic [31:0]        d_tag;
  logic [PORT_W-1:0]  d_port;

  logic [ENTRIES-1:0] match;
  logic               hit;
  logic [IDX_W-1:0]   sel;
  logic [1:0]         act;
  logic [31:0]        act_tag;
  logic [PORT_W-1:0]  act_port;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (cfg_idx == IDX_W'(i)) begin
          if (cfg_del)     vld[i] <= 1'b0;
          else if (cfg_wr) vld[i] <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (cfg_wr && !cfg_del && cfg_idx == IDX_W'(i)) begin
        k_dmac[i] <= cfg_dmac;
        k_vid[i]  <= cfg_vid;
        e_act[i]  <= cfg_act;
        e_tag[i]  <= cfg_tag;
        e_port[i] <= cfg_port;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_act  <= '0;
      d_tag  <= '0;
      d_port <= '0;
    end else if (cfg_dflt_wr) begin
      d_act  <= cfg_act;
      d_tag  <= cfg_tag;
      d_port <= cfg_port;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = vld[g] && (k_dmac[g] == in_dmac) && (k_vid[g] == in_vid);
  end

  always_comb begin
    hit = 1'b0;
    sel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit = 1'b1;
        sel = IDX_W'(i);
      end
    end
  end

  assign act      = hit ? e_act[sel]  : d_act;
  assign act_tag  = hit ? e_tag[sel]  : d_tag;
  assign act_port = hit ? e_port[sel] : d_port;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid       <= 1'b0;
      out_hit         <= 1'b0;
      out_drop        <= 1'b0;
      out_dmac        <= '0;
      out_vid         <= '0;
      out_tag_present <= 1'b0;
      out_tag         <= '0;
      out_egress      <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_hit         <= hit;
        out_drop        <= (act == ACT_DROP);
        out_dmac        <= in_dmac;
        out_vid         <= in_vid;
        out_tag_present <= (act == ACT_INSERT) ? 1'b1     : in_tag_present;
        out_tag         <= (act == ACT_INSERT) ? act_tag  : in_tag;
        out_egress      <= (act == ACT_INSERT) ? act_port : in_egress;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(out_tag) && $stable(out_dmac) && $stable(out_egress)); // R2
  AST_KEY_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_dmac == $past(in_dmac) && out_vid == $past(in_vid)); // R3
  AST_DROP_UNCHANGED: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid ##1 out_drop |-> out_tag == $past(in_tag) && out_egress == $past(in_egress)); // R4
  AST_DELETE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_del && (int'(cfg_idx) < ENTRIES) |=> !vld[$past(cfg_idx)]); // R8
endmodule

// File: tb/tag_insert_table_test.sv
`timescale 1ns/1ps
module tag_insert_table_test;
  localparam int N = 8;
  localparam int PW = 4;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_tag_present = 0;
  logic [47:0] in_dmac = 0;
  logic [11:0] in_vid = 0;
  logic [31:0] in_tag = 0;
  logic [PW-1:0] in_egress = 0;
  logic cfg_wr = 0, cfg_del = 0, cfg_dflt_wr = 0;
  logic [2:0] cfg_idx = 0;
  logic [47:0] cfg_dmac = 0;
  logic [11:0] cfg_vid = 0;
  logic [1:0] cfg_act = 0;
  logic [31:0] cfg_tag = 0;
  logic [PW-1:0] cfg_port = 0;
  logic out_valid, out_hit, out_drop, out_tag_present;
  logic [47:0] out_dmac;
  logic [11:0] out_vid;
  logic [31:0] out_tag;
  logic [PW-1:0] out_egress;

  tag_insert_table #(.ENTRIES(N), .PORT_W(PW)) uut (.*);

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  string cur_req = "R10";

  bit m_vld[N];
  logic [47:0] m_dmac[N];
  logic [11:0] m_vid[N];
  logic [1:0] m_act[N];
  logic [31:0] m_tag[N];
  logic [PW-1:0] m_port[N];
  logic [1:0] md_act = 0;
  logic [31:0] md_tag = 0;
  logic [PW-1:0] md_port = 0;

  logic e_valid = 0, e_hit = 0, e_drop = 0, e_tp = 0;
  logic [47:0] e_dmac = 0;
  logic [11:0] e_vid = 0;
  logic [31:0] e_tag = 0;
  logic [PW-1:0] e_eg = 0;

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    int idx = -1;
    logic [1:0] a;
    logic [31:0] t;
    logic [PW-1:0] p;
    for (int i = 0; i < N; i++)
      if (idx < 0 && m_vld[i] && m_dmac[i] == in_dmac && m_vid[i] == in_vid) idx = i;
    a = (idx >= 0) ? m_act[idx] : md_act;
    t = (idx >= 0) ? m_tag[idx] : md_tag;
    p = (idx >= 0) ? m_port[idx] : md_port;
    e_valid = in_valid;
    if (in_valid) begin
      e_hit = (idx >= 0);
      e_drop = (a == 2'd2);
      e_dmac = in_dmac;
      e_vid = in_vid;
      e_tp = (a == 2'd1) ? 1'b1 : in_tag_present;
      e_tag = (a == 2'd1) ? t : in_tag;
      e_eg = (a == 2'd1) ? p : in_egress;
    end
    if (cfg_dflt_wr) begin md_act = cfg_act; md_tag = cfg_tag; md_port = cfg_port; end
    if (cfg_del) m_vld[cfg_idx] = 0;
    else if (cfg_wr) begin
      m_vld[cfg_idx] = 1; m_dmac[cfg_idx] = cfg_dmac; m_vid[cfg_idx] = cfg_vid;
      m_act[cfg_idx] = cfg_act; m_tag[cfg_idx] = cfg_tag; m_port[cfg_idx] = cfg_port;
    end
    @(posedge clk);
    @(negedge clk);
    chk(cur_req, "valid", out_valid, e_valid);
    chk(cur_req, "hit", out_hit, e_hit);
    chk(cur_req, "drop", out_drop, e_drop);
    chk(cur_req, "dmac", out_dmac, e_dmac);
    chk(cur_req, "vid", out_vid, e_vid);
    chk(cur_req, "tag_present", out_tag_present, e_tp);
    chk(cur_req, "tag", out_tag, e_tag);
    chk(cur_req, "egress", out_egress, e_eg);
    cfg_wr = 0; cfg_del = 0; cfg_dflt_wr = 0; in_valid = 0;
  endtask

  task automatic lookup(logic [47:0] d, logic [11:0] v, logic tp, logic [31:0] t, logic [PW-1:0] e);
    in_valid = 1; in_dmac = d; in_vid = v; in_tag_present = tp; in_tag = t; in_egress = e;
  endtask

  task automatic put(int i, logic [47:0] d, logic [11:0] v, logic [1:0] a, logic [31:0] t, logic [PW-1:0] p);
    cfg_wr = 1; cfg_idx = 3'(i); cfg_dmac = d; cfg_vid = v; cfg_act = a; cfg_tag = t; cfg_port = p;
  endtask

  localparam logic [47:0] KA = 48'h0011_2233_4455;
  localparam logic [47:0] KB = 48'h00AA_BBCC_DDEE;
  localparam logic [11:0] VA = 12'h064;

  initial begin : main
    logic [15:0] lf = 16'hACE1;
    @(negedge clk);
    chk("R10", "valid in reset", out_valid, 0);
    rst_n = 1;
    cur_req = "R10";
    lookup(KA, VA, 0, 32'h0, 4'h3); step();
    chk("R10", "empty table misses", out_hit, 0);

    cur_req = "R3";
    put(2, KA, VA, 2'd1, 32'h0A0B0C0D, 4'h5); step();
    lookup(KA, VA, 0, 32'h0, 4'h1); step();
    chk("R3", "inserted tag", out_tag, 32'h0A0B0C0D);
    cur_req = "R1";
    lookup(KA, VA + 12'd1, 0, 0, 4'h1); step();
    chk("R1", "vid mismatch misses", out_hit, 0);
    lookup(KA ^ 48'h1, VA, 0, 0, 4'h1); step();
    chk("R1", "address mismatch misses", out_hit, 0);

    cur_req = "R4";
    put(5, KB, VA, 2'd2, 32'hFFFF0000, 4'h9); step();
    lookup(KB, VA, 1, 32'h12345678, 4'h2); step();
    chk("R4", "drop flag", out_drop, 1);
    cur_req = "R5";
    put(6, KB, 12'h001, 2'd0, 32'h11111111, 4'h7); step();
    put(7, KB, 12'h002, 2'd3, 32'h22222222, 4'h8); step();
    lookup(KB, 12'h001, 0, 32'h5, 4'h2); step();
    lookup(KB, 12'h002, 1, 32'h6, 4'h4); step();
    chk("R5", "code 3 keeps tag", out_tag, 32'h6);

    cur_req = "R7";
    put(1, KA, VA, 2'd1, 32'hC0C1C2C3, 4'hE); step();
    lookup(KA, VA, 0, 0, 0); step();
    chk("R7", "lower index wins", out_tag, 32'hC0C1C2C3);
    cur_req = "R8";
    cfg_del = 1; cfg_idx = 3'd1; step();
    lookup(KA, VA, 0, 0, 0); step();
    chk("R8", "after delete next entry", out_tag, 32'h0A0B0C0D);
    put(3, KB, 12'h333, 2'd1, 32'h33333333, 4'h3); cfg_del = 1; step();
    lookup(KB, 12'h333, 0, 0, 0); step();
    chk("R8", "delete beats write", out_hit, 0);

    cur_req = "R9";
    put(4, KB, 12'h444, 2'd1, 32'h44444444, 4'h4); lookup(KB, 12'h444, 0, 0, 0); step();
    chk("R9", "same-cycle write unseen", out_hit, 0);
    lookup(KB, 12'h444, 0, 0, 0); step();
    chk("R9", "write seen next", out_hit, 1);
    cfg_del = 1; cfg_idx = 3'd4; lookup(KB, 12'h444, 0, 0, 0); step();
    chk("R9", "same-cycle delete unseen", out_hit, 1);

    cur_req = "R6";
    cfg_dflt_wr = 1; cfg_act = 2'd1; cfg_tag = 32'hDEFA017D; cfg_port = 4'hD;
    lookup(48'h5, 12'h5, 0, 0, 4'h1); step();
    chk("R6", "old default in write cycle", out_tag_present, 0);
    lookup(48'h5, 12'h5, 0, 0, 4'h1); step();
    chk("R6", "default insert port", out_egress, 4'hD);

    cur_req = "R11";
    lookup(KA, VA, 1, 32'hBADBAD00, 4'hF); step();
    chk("R11", "incoming tag replaced", out_tag, 32'h0A0B0C0D);

    cur_req = "R2";
    step(); step();
    chk("R2", "held tag while idle", out_tag, 32'h0A0B0C0D);

    cur_req = "R1";
    for (int n = 0; n < 400; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (lf[0]) lookup(lf[3] ? KA : KB, {10'd0, lf[5:4]}, lf[6], {16'h0, lf}, lf[11:8]);
      if (lf[7] && lf[1]) put(lf[10:8], lf[2] ? KA : KB, {10'd0, lf[13:12]}, lf[15:14], {lf, lf}, lf[4:1]);
      else if (lf[7]) begin cfg_del = 1; cfg_idx = lf[10:8]; end
      step();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : watchdog
    #500000;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule